// File: doc/BRIEF.md
# Keyed-Refresh Watchdog Timer

This block is a watchdog timer for a processor subsystem, reached through a simple register write port and a combinational read port. Software first stores a reload value and then turns the timer on through a control register. From then on it has to refresh the timer before it runs out. A refresh is valid only when two key values reach the refresh register back to back. A single write cannot restart the count, so code that has run away is unlikely to keep the timer alive by chance.

A down-counter advances once for every four bus clock cycles. When it runs out and the reset option is on, the block sends a single-cycle request to the system reset controller and sets a sticky cause flag. The flag is cleared by power-on reset and by an explicit software clear. The ordinary system reset does not touch it, so boot code can tell that the last restart came from the watchdog.

Top module: `feed_wdt`

## Requirements
- R1: After power-on reset (`por_ni` and `rst_ni` both low), the reload register and the counter read `TC_RST`, the control register reads 0 and `rst_req_o` is low.
- R2: Register addresses are: 0 = reload value (read/write), 1 = control, 2 = refresh (write-only, reads 0), 3 = current count (read-only; writes are ignored).
- R3: Writing 0x00AA to address 2 and then 0x0055 to address 2 in the next write loads the counter from the reload register and restarts the prescaler. This works whether or not the timer is enabled.
- R4: A refresh sequence is aborted, with no reload, if any other write comes between 0x00AA and 0x0055. This covers a write to another address and any other value written to address 2. A 0x0055 write with no 0x00AA before it is ignored, and a repeated 0x00AA re-arms the sequence.
- R5: While the timer is enabled, the counter decreases by one every 4 clock cycles. The first decrement happens on the 4th rising edge after the edge that captures the 0x0055 write.
- R6: If the reset option is on and a refresh with reload value N is captured at edge P, `rst_req_o` is high for exactly one cycle after edge P+4·max(N,1). A reload value of 0 behaves like 1.
- R7: Control bit 0 enables the timer. A write can set it but cannot clear it. Only `rst_ni` clears it.
- R8: Control bit 1 turns on the reset option. When the counter expires with this bit low, the counter reloads from the reload register, `rst_req_o` stays low and the cause flag is unchanged.
- R9: Control bit 2 is the cause flag. It is set when an expiry raises `rst_req_o` and stays set through `rst_ni`. It is cleared by `por_ni` or by a control write whose bit 2 is 0. Writing 1 to bit 2 does not set it.
- R10: While the timer is disabled, the counter holds its value except when a valid refresh loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset; also clears the cause flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DW | Read data, combinational from `rd_addr_i` |
| rst_req_o | output | 1 | Single-cycle system reset request |

## Verification
The bench builds the block with its default parameters: a 16-bit data path, `TC_RST` = 0xFFFF and a fixed divide-by-4 prescaler. Reload values are kept between 0 and 12, so each timeout is at most 48 cycles. Every expiry can therefore be timed exactly from the refresh edge, including the case where a reload value of 0 is treated as 1. The large reset value leaves a frozen counter clearly different from any reload value the bench writes. This makes aborted and ignored refresh sequences visible through the count register.

// File: rtl/feed_wdt_pkg.sv
`timescale 1ns/1ps
package feed_wdt_pkg;
  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_CTRL   = 2'd1,
    REG_KICK   = 2'd2,
    REG_COUNT  = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_RST_BIT  = 1;
  localparam int unsigned CTRL_FLAG_BIT = 2;

  localparam logic [7:0] KEY_ARM  = 8'hAA;
  localparam logic [7:0] KEY_FIRE = 8'h55;
endpackage

// File: rtl/feed_wdt_regs.sv
`timescale 1ns/1ps
module feed_wdt_regs
  import feed_wdt_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter logic [DW-1:0] TC_RST = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    rd_addr_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          expire_i,
  output logic [DW-1:0] tc_o,
  output logic          en_o,
  output logic          rst_en_o,
  output logic          flag_o,
  output logic [DW-1:0] rd_data_o
);
  logic          wr_tc, wr_ctrl;
  logic [DW-1:0] tc_q;
  logic          en_q, rst_en_q, flag_q;

  assign wr_tc   = wr_en_i && (wr_addr_i == REG_RELOAD);
  assign wr_ctrl = wr_en_i && (wr_addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q     <= TC_RST;
      en_q     <= 1'b0;
      rst_en_q <= 1'b0;
    end else begin
      if (wr_tc) tc_q <= wr_data_i;
      if (wr_ctrl) begin
        en_q     <= en_q | wr_data_i[CTRL_EN_BIT];  // set-only
        rst_en_q <= wr_data_i[CTRL_RST_BIT];
      end
    end
  end

  // cause flag lives in the power-on domain
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                                  flag_q <= 1'b0;
    else if (expire_i && rst_en_q)                flag_q <= 1'b1;
    else if (wr_ctrl && !wr_data_i[CTRL_FLAG_BIT]) flag_q <= 1'b0;
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      REG_RELOAD: rd_data_o = tc_q;
      REG_CTRL: begin
        rd_data_o[CTRL_EN_BIT]   = en_q;
        rd_data_o[CTRL_RST_BIT]  = rst_en_q;
        rd_data_o[CTRL_FLAG_BIT] = flag_q;
      end
      REG_KICK:  rd_data_o = '0;
      REG_COUNT: rd_data_o = cnt_i;
      default:   rd_data_o = '0;
    endcase
  end

  assign tc_o     = tc_q;
  assign en_o     = en_q;
  assign rst_en_o = rst_en_q;
  assign flag_o   = flag_q;

  // R7
  en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
  // R9
  flag_no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !expire_i) |=> !flag_q);
endmodule

// File: rtl/feed_wdt_kick.sv
`timescale 1ns/1ps
module feed_wdt_kick
  import feed_wdt_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          kick_o
);
  localparam logic [DW-1:0] ARM_W  = DW'(KEY_ARM);
  localparam logic [DW-1:0] FIRE_W = DW'(KEY_FIRE);

  logic kick_wr, armed_q;

  assign kick_wr = wr_en_i && (wr_addr_i == REG_KICK);
  assign kick_o  = armed_q && kick_wr && (wr_data_i == FIRE_W);

  // any write re-evaluates the armed state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (wr_en_i) armed_q <= kick_wr && (wr_data_i == ARM_W);
  end

  // R4
  seq_consumed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |=> !armed_q);
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !armed_q) |=> !armed_q);
endmodule

// File: rtl/feed_wdt_counter.sv
`timescale 1ns/1ps
module feed_wdt_counter #(
  parameter int unsigned DW        = 16,
  parameter int unsigned PRESC_DIV = 4,
  parameter logic [DW-1:0] TC_RST  = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          rst_en_i,
  input  logic          kick_i,
  input  logic [DW-1:0] tc_i,
  output logic [DW-1:0] cnt_o,
  output logic          expire_o,
  output logic          rst_req_o
);
  localparam int unsigned PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0] presc_q;
  logic [DW-1:0] cnt_q;
  logic          tick, rst_req_q;

  assign tick     = en_i && !kick_i && (presc_q == P_LAST);
  assign expire_o = tick && (cnt_q <= DW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     presc_q <= '0;
    else if (kick_i) presc_q <= '0;
    else if (en_i)   presc_q <= (presc_q == P_LAST) ? '0 : presc_q + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= TC_RST;
    else if (kick_i || expire_o) cnt_q <= tc_i;
    else if (tick)            cnt_q <= cnt_q - DW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= expire_o && rst_en_i;
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = rst_req_q;

  // R3
  kick_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == $past(tc_i)));
  // R5
  no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kick_i && !expire_o) |=> (cnt_q <= $past(cnt_q)));
  // R5
  presc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_q <= P_LAST);
  // R10
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !kick_i) |=> $stable(cnt_q));
  // R6
  one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> !rst_req_q);
endmodule

// File: rtl/feed_wdt.sv
`timescale 1ns/1ps
module feed_wdt #(
  parameter int unsigned DW        = 16,
  parameter int unsigned PRESC_DIV = 4,
  parameter logic [DW-1:0] TC_RST  = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rst_req_o
);
  logic [DW-1:0] tc, cnt;
  logic          en, rst_en, flag, kick, expire;

  feed_wdt_regs #(.DW(DW), .TC_RST(TC_RST)) regs_i (
    .clk_i, .rst_ni, .por_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .cnt_i(cnt), .expire_i(expire), .tc_o(tc), .en_o(en),
    .rst_en_o(rst_en), .flag_o(flag), .rd_data_o
  );

  feed_wdt_kick #(.DW(DW)) kick_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .kick_o(kick)
  );

  feed_wdt_counter #(.DW(DW), .PRESC_DIV(PRESC_DIV), .TC_RST(TC_RST)) cnt_i (
    .clk_i, .rst_ni, .en_i(en), .rst_en_i(rst_en), .kick_i(kick), .tc_i(tc),
    .cnt_o(cnt), .expire_o(expire), .rst_req_o
  );

  // R9
  req_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> flag);
  // R8
  req_needs_opt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(rst_en));
endmodule

// File: tb/feed_wdt_tb.sv
`timescale 1ns/1ps
module feed_wdt_tb_top;
  localparam int unsigned DW = 16;
  localparam logic [DW-1:0] TC_RST = 16'hFFFF;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          por_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [1:0]    rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          rst_req_o;

  int errs = 0;
  int chks = 0;

  always #2 clk_i = ~clk_i;

  feed_wdt #(.DW(DW), .PRESC_DIV(4), .TC_RST(TC_RST)) dut_i (
    .clk_i, .rst_ni, .por_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .rst_req_o
  );

  function automatic int exp_period(input int n);
    return 4 * ((n == 0) ? 1 : n);
  endfunction

  function automatic int exp_cnt(input int n, input int j);
    return n - j / 4;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    rd_addr_i = a;
    #0.1;
    d = rd_data_o;
  endtask

  task automatic kick();
    wr(2'd2, 16'h00AA);
    wr(2'd2, 16'h0055);
  endtask

  task automatic sys_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic wait_req(input int limit, output int k);
    k = 0;
    while (k < limit) begin
      @(posedge clk_i);
      @(negedge clk_i);
      k++;
      if (rst_req_o) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errs++; chks++;
    $display("FAIL watchdog run hung act=running exp=done");
    $display("  Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int k, n, m, ep;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk_i);
    por_ni = 1'b1; rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(2'd0, d); chk(d == TC_RST, "R1 reload", d, TC_RST);
    rd(2'd1, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(2'd3, d); chk(d == TC_RST, "R1 count", d, TC_RST);
    chk(rst_req_o == 1'b0, "R1 rst_req", rst_req_o, 0);

    // R2 map, count read-only
    wr(2'd0, 16'd7);
    rd(2'd0, d); chk(d == 7, "R2 reload rw", d, 7);
    wr(2'd3, 16'h0123);
    rd(2'd3, d); chk(d == TC_RST, "R2 count ro", d, TC_RST);
    rd(2'd2, d); chk(d == 0, "R2 kick reads 0", d, 0);

    // R4 aborted / ignored sequences (timer disabled, counter frozen)
    wr(2'd2, 16'h00AA); wr(2'd0, 16'd7); wr(2'd2, 16'h0055);
    rd(2'd3, d); chk(d == TC_RST, "R4 other addr aborts", d, TC_RST);
    wr(2'd2, 16'h00AA); wr(2'd2, 16'h0012); wr(2'd2, 16'h0055);
    rd(2'd3, d); chk(d == TC_RST, "R4 other value aborts", d, TC_RST);
    wr(2'd2, 16'h0055);
    rd(2'd3, d); chk(d == TC_RST, "R4 lone fire ignored", d, TC_RST);
    wr(2'd2, 16'h00AA); wr(2'd2, 16'h00AA); wr(2'd2, 16'h0055);
    rd(2'd3, d); chk(d == 7, "R4 rearm reloads", d, 7);

    // R3 refresh while disabled, R10 hold
    wr(2'd0, 16'd5);
    kick();
    rd(2'd3, d); chk(d == 5, "R3 reload disabled", d, 5);
    repeat (20) @(negedge clk_i);
    rd(2'd3, d); chk(d == 5, "R10 frozen", d, 5);

    // R5 / R8 enabled without reset option
    wr(2'd1, 16'h0001);
    kick();
    for (int j = 1; j <= 20; j++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (rst_req_o) chk(1'b0, "R8 no request", 1, 0);
      if (j == 3)  begin rd(2'd3, d); chk(d == 5, "R5 before tick", d, 5); end
      if (j == 4)  begin rd(2'd3, d); chk(d == exp_cnt(5, 4), "R5 first tick", d, exp_cnt(5, 4)); end
      if (j == 19) begin rd(2'd3, d); chk(d == 1, "R5 last", d, 1); end
      if (j == 20) begin rd(2'd3, d); chk(d == 5, "R8 auto reload", d, 5); end
    end
    rd(2'd1, d); chk(d == 16'h1, "R8 flag unchanged", d, 1);

    // R7 enable cannot be cleared
    wr(2'd1, 16'h0000);
    rd(2'd1, d); chk(d == 16'h1, "R7 sticky enable", d, 1);

    // R6 timed expiry with reset option
    wr(2'd1, 16'h0003);
    wr(2'd0, 16'd3);
    kick();
    wait_req(exp_period(3) + 8, k);
    chk(k == exp_period(3), "R6 period", k, exp_period(3));
    rd(2'd1, d); chk(d[2] == 1'b1, "R9 flag set", d[2], 1);
    @(posedge clk_i); @(negedge clk_i);
    chk(rst_req_o == 1'b0, "R6 one cycle", rst_req_o, 0);
    sys_reset();
    rd(2'd1, d); chk(d == 16'h4, "R9 survives rst / R7 en cleared", d, 4);

    // R9 software write semantics
    wr(2'd1, 16'h0004);
    rd(2'd1, d); chk(d == 16'h4, "R9 write 1 keeps", d, 4);
    wr(2'd1, 16'h0000);
    rd(2'd1, d); chk(d == 16'h0, "R9 write 0 clears", d, 0);
    wr(2'd1, 16'h0004);
    rd(2'd1, d); chk(d == 16'h0, "R9 write 1 no set", d, 0);

    // R6 random reload values, with optional early refresh
    for (int it = 0; it < 16; it++) begin
      n  = $urandom % 13;
      ep = exp_period(n);
      wr(2'd1, 16'h0003);
      wr(2'd0, DW'(n));
      kick();
      if ($urandom % 2 == 1) begin
        m = $urandom % (ep - 2);
        for (int j = 0; j < m; j++) begin
          @(posedge clk_i); @(negedge clk_i);
          if (rst_req_o) chk(1'b0, "R6 early request", 1, 0);
        end
        kick();
      end
      wait_req(ep + 8, k);
      chk(k == ep, "R6 random period", k, ep);
      sys_reset();
      rd(2'd1, d); chk(d == 16'h4, "R9 random flag", d, 4);
    end

    // R9 power-on reset clears flag
    @(negedge clk_i); por_ni = 1'b0; rst_ni = 1'b0;
    @(negedge clk_i); por_ni = 1'b1; rst_ni = 1'b1;
    rd(2'd1, d); chk(d == 16'h0, "R9 por clears", d, 0);

    $display("  Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule